// File: doc/BRIEF.md
# Clock-Enable Low-Power State Tracker

This block follows, on the memory device side, which low-power state a low-power DDR memory is in. A falling clock enable starts every entry into a low-power state. The command presented on the three low command/address bits in that same cycle picks the state. A refresh command selects self-refresh. A burst-terminate command selects deep power-down. Any other command selects plain power-down, and so does a cycle with chip select deasserted, which counts as a NOP.

When the clock enable rises again, power-down and self-refresh go back to active. Deep power-down does not. It moves to a reset-pending state that only the reset input can clear, and a flag asks the host for a full reset sequence. The block sees only the command pins and the clock enable line. A controller or a device model can use it to decide when command decoding is allowed and when a reset sequence is needed.

Top module: `lp_cke_power_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the state output is ACTIVE (code 0) and the reset-request flag is low.
- R2: If the clock enable was high at the previous rising edge and is low at this edge, with chip select low and the command bits equal to 3'b100 (bit 0 = CA0, so CA0 low, CA1 low, CA2 high), the state becomes SELF_REFRESH (code 2) after this edge.
- R3: The same falling clock enable with chip select low and command bits 3'b011 (CA0 high, CA1 high, CA2 low) moves the state to DEEP_PD (code 3).
- R4: A falling clock enable while ACTIVE with any other command, or with chip select high (NOP, whatever the command bits), moves the state to POWER_DOWN (code 1).
- R5: In POWER_DOWN or SELF_REFRESH, a high clock enable at a rising edge returns the state to ACTIVE.
- R6: In DEEP_PD, a high clock enable moves the state to RESET_WAIT (code 4). RESET_WAIT is held whatever the clock enable, chip select and command bits do, until reset is asserted.
- R7: The reset-request flag is high exactly while the state is DEEP_PD or RESET_WAIT.
- R8: In any low-power state, while the clock enable stays low, the commands on the pins have no effect on the state.
- R9: In ACTIVE, a clock enable that is low without having been high at the previous edge (for example, held low through reset release) does not start a low-power entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state is updated on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; also the only exit from RESET_WAIT |
| cke_i | input | 1 | Clock enable line from the host |
| cs_ni | input | 1 | Active-low chip select; high means NOP |
| ca_i | input | 3 | Low command/address bits, bit 0 = CA0 |
| lp_state_o | output | 3 | State code: 0 ACTIVE, 1 POWER_DOWN, 2 SELF_REFRESH, 3 DEEP_PD, 4 RESET_WAIT |
| need_reset_o | output | 1 | High while a full reset sequence is required |

## Verification
Two functions meet in one cycle: detecting the clock-enable edge and decoding the command, because the entry state is chosen by whatever command is on the pins when the enable falls. The bench provokes this by dropping the enable while each of the refresh code, the burst-terminate code, an unrelated code, and a deselected cycle that carries the refresh code are present. A second overlap comes when a command arrives while the enable stays low in a low-power state, or while it sits low after reset with no preceding high sample. In every case a behavioural model picks the expected state and flag, and the outputs are compared with it on every clock.

// File: rtl/lp_pkg.sv
package lp_pkg;

  typedef enum logic [2:0] {
    LP_ACTIVE     = 3'd0,
    LP_POWER_DOWN = 3'd1,
    LP_SELF_REF   = 3'd2,
    LP_DEEP_PD    = 3'd3,
    LP_RESET_WAIT = 3'd4
  } lp_state_e;

  // Command match: only valid when chip select is asserted (low).
  function automatic logic cmd_match(input logic cs_n, input logic [2:0] ca,
                                     input logic [2:0] code);
    return (!cs_n) && (ca == code);
  endfunction

  // State chosen on a falling clock enable.
  function automatic lp_state_e entry_state(input logic sref, input logic dpd);
    if (dpd)       return LP_DEEP_PD;
    else if (sref) return LP_SELF_REF;
    else           return LP_POWER_DOWN;
  endfunction

  function automatic logic is_low_power(input lp_state_e s);
    return s != LP_ACTIVE;
  endfunction

  function automatic logic wants_reset(input lp_state_e s);
    return (s == LP_DEEP_PD) || (s == LP_RESET_WAIT);
  endfunction

endpackage

// File: rtl/lp_cmd_decode.sv
module lp_cmd_decode #(
  parameter int          CA_W      = 3,
  parameter logic [2:0]  SREF_CODE = 3'b100,
  parameter logic [2:0]  DPD_CODE  = 3'b011
) (
  input  logic            cs_ni,
  input  logic [CA_W-1:0] ca_i,
  output logic            cmd_sref_o,
  output logic            cmd_dpd_o
);
  import lp_pkg::*;

  localparam int LOW_W = 3;
  logic [LOW_W-1:0] ca_low;

  generate
    if (CA_W > LOW_W) begin : g_wide
      assign ca_low = ca_i[LOW_W-1:0];
    end else begin : g_narrow
      assign ca_low = LOW_W'(ca_i);
    end
  endgenerate

  assign cmd_sref_o = cmd_match(cs_ni, ca_low, SREF_CODE);
  assign cmd_dpd_o  = cmd_match(cs_ni, ca_low, DPD_CODE);

endmodule

// File: rtl/lp_cke_edge.sv
module lp_cke_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic cke_fall_o,
  output logic cke_high_o
);
  logic cke_q;

  // Resets low so a line held low through reset is not seen as falling.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  assign cke_fall_o = cke_q && !cke_i;
  assign cke_high_o = cke_i;

endmodule

// File: rtl/lp_state_fsm.sv
module lp_state_fsm (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_fall_i,
  input  logic             cke_high_i,
  input  logic             cmd_sref_i,
  input  logic             cmd_dpd_i,
  output lp_pkg::lp_state_e state_o,
  output logic             need_reset_o
);
  import lp_pkg::*;

  lp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LP_ACTIVE:     if (cke_fall_i) state_d = entry_state(cmd_sref_i, cmd_dpd_i);
      LP_POWER_DOWN: if (cke_high_i) state_d = LP_ACTIVE;
      LP_SELF_REF:   if (cke_high_i) state_d = LP_ACTIVE;
      LP_DEEP_PD:    if (cke_high_i) state_d = LP_RESET_WAIT;
      LP_RESET_WAIT: state_d = LP_RESET_WAIT;
      default:       state_d = LP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LP_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign need_reset_o = wants_reset(state_q);

  assert_sref_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_ACTIVE && cke_fall_i && cmd_sref_i) |=> (state_q == LP_SELF_REF));

  assert_dpd_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_ACTIVE && cke_fall_i && cmd_dpd_i) |=> (state_q == LP_DEEP_PD));

  assert_pd_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_ACTIVE && cke_fall_i && !cmd_sref_i && !cmd_dpd_i)
      |=> (state_q == LP_POWER_DOWN));

  assert_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == LP_POWER_DOWN || state_q == LP_SELF_REF) && cke_high_i)
      |=> (state_q == LP_ACTIVE));

  assert_reset_wait_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_RESET_WAIT) |=> (state_q == LP_RESET_WAIT));

  assert_flag_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(need_reset_o) |-> ($past(state_q) == LP_ACTIVE && state_q == LP_DEEP_PD));

  assert_lowpower_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != LP_ACTIVE && !cke_high_i) |=> $stable(state_q));

  assert_no_entry_without_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LP_ACTIVE && !cke_fall_i) |=> (state_q == LP_ACTIVE));

endmodule

// File: rtl/lp_cke_power_ctrl.sv
module lp_cke_power_ctrl #(
  parameter int         CA_W      = 3,
  parameter logic [2:0] SREF_CODE = 3'b100,
  parameter logic [2:0] DPD_CODE  = 3'b011,
  localparam int        ST_W      = $bits(lp_pkg::lp_state_e)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  logic            cs_ni,
  input  logic [CA_W-1:0] ca_i,
  output logic [ST_W-1:0] lp_state_o,
  output logic            need_reset_o
);
  import lp_pkg::*;

  logic      cke_fall, cke_high;
  logic      cmd_sref, cmd_dpd;
  lp_state_e state;

  lp_cke_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .cke_fall_o (cke_fall),
    .cke_high_o (cke_high)
  );

  lp_cmd_decode #(
    .CA_W      (CA_W),
    .SREF_CODE (SREF_CODE),
    .DPD_CODE  (DPD_CODE)
  ) u_decode (
    .cs_ni      (cs_ni),
    .ca_i       (ca_i),
    .cmd_sref_o (cmd_sref),
    .cmd_dpd_o  (cmd_dpd)
  );

  lp_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cke_fall_i   (cke_fall),
    .cke_high_i   (cke_high),
    .cmd_sref_i   (cmd_sref),
    .cmd_dpd_i    (cmd_dpd),
    .state_o      (state),
    .need_reset_o (need_reset_o)
  );

  assign lp_state_o = state;

  assert_flag_matches_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_state_o == 3'd0 || lp_state_o == 3'd1 || lp_state_o == 3'd2) |-> !need_reset_o);

endmodule

// File: tb/test_lp_cke_power_ctrl.sv
`timescale 1ns/1ps
module test_lp_cke_power_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic       cs_n = 1'b1;
  logic [2:0] ca = 3'd0;
  logic [2:0] st;
  logic       nr;

  int compared = 0;
  int mismatched = 0;
  int m_state = 0;
  bit m_prev = 1'b0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  lp_cke_power_ctrl i_lp_cke_power_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ca_i(ca),
    .lp_state_o(st), .need_reset_o(nr)
  );

  // Behavioural reference: state numbers 0..4 as listed in the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0;
      m_prev  = 1'b0;
    end else begin
      if (m_state == 0) begin
        if (m_prev && !cke) begin
          if (!cs_n && ca == 3'b100)      m_state = 2;
          else if (!cs_n && ca == 3'b011) m_state = 3;
          else                            m_state = 1;
        end
      end else if (m_state == 1 || m_state == 2) begin
        if (cke) m_state = 0;
      end else if (m_state == 3) begin
        if (cke) m_state = 4;
      end
      m_prev = cke;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (int'(st) != m_state || nr != (m_state == 3 || m_state == 4)) begin
        mismatched++;
        $display("FAIL %s state=%0d flag=%0b expected state=%0d flag=%0b at %0t",
                 cur_req, st, nr, m_state, (m_state == 3 || m_state == 4), $time);
      end
    end
  end

  task automatic cyc(input bit k, input bit c, input logic [2:0] a, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cke = k; cs_n = c; ca = a;
    end
  endtask

  task automatic do_reset(input bit k);
    @(negedge clk); #1;
    rst_n = 1'b0; cke = k; cs_n = 1'b1;
    cyc(k, 1'b1, 3'd0, 2);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    cur_req = "R1";
    do_reset(1'b1);
    cyc(1, 1, 3'd0, 3);
    // R9: enable low through reset release: no entry
    cur_req = "R9";
    do_reset(1'b0);
    cyc(0, 0, 3'b100, 3);
    cyc(0, 1, 3'd0, 2);
    // R4: NOP (deselected refresh code) on falling enable -> power-down
    cur_req = "R4";
    cyc(1, 1, 3'd0, 2);
    cyc(0, 1, 3'b100, 1);
    cur_req = "R8";
    cyc(0, 0, 3'b011, 2);
    cyc(0, 0, 3'b100, 2);
    cur_req = "R5";
    cyc(1, 1, 3'd0, 2);
    // R2: refresh code -> self-refresh
    cur_req = "R2";
    cyc(0, 0, 3'b100, 1);
    cur_req = "R8";
    cyc(0, 0, 3'b011, 2);
    cur_req = "R5";
    cyc(1, 0, 3'b100, 2);
    // R4: unrelated code -> power-down
    cur_req = "R4";
    cyc(0, 0, 3'b111, 1);
    cyc(0, 0, 3'b000, 1);
    cyc(1, 1, 3'd0, 2);
    // R3 / R7: burst-terminate code -> deep power-down
    cur_req = "R3";
    cyc(0, 0, 3'b011, 1);
    cur_req = "R7";
    cyc(0, 0, 3'b100, 2);
    // R6: enable high -> reset wait, held under all stimulus
    cur_req = "R6";
    cyc(1, 1, 3'd0, 2);
    cyc(0, 0, 3'b100, 2);
    cyc(1, 0, 3'b011, 2);
    cyc(0, 0, 3'b011, 2);
    cyc(1, 1, 3'd0, 2);
    cur_req = "R1";
    do_reset(1'b1);
    cyc(1, 1, 3'd0, 3);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule